// File: doc/BRIEF.md
# Audio Sample-Rate Mode Detector

This block works out which speed class an incoming stereo audio stream belongs to. It watches the frame clock, where one period is one stereo frame and so the frame rate is the sample rate. It times each frame in cycles of a free-running reference clock whose frequency is a parameter. The measured period is placed in one of three disjoint bands: single speed (4 kHz to 54 kHz), double speed (84 kHz to 108 kHz) or quad speed (170 kHz to 216 kHz). A rate that falls in a gap between bands, or outside all of them, is reported as unsupported and is never rounded to the nearest band.

In the same frame the block counts master-clock rising edges. The master clock is the oversampling clock that the frame clock is divided from, so this count is the oversampling ratio. The block encodes the ratio and flags it when it is not allowed for the detected band. A result is published only once two frames in a row give the same answer. If the frame clock stops, the block falls back to the unsupported state after a timeout.

Top module: `srate_mode_det`

## Requirements
- R1: While reset is held, and after its release until the first commit, every output is 0.
- R2: With P the number of reference cycles from one frame-clock rising edge to the next, a P within ceil(REF_HZ/216000)..floor(REF_HZ/170000) classifies as quad speed, mode code 3.
- R3: A P within ceil(REF_HZ/108000)..floor(REF_HZ/84000) classifies as double speed, mode code 2.
- R4: A P within ceil(REF_HZ/54000)..floor(REF_HZ/4000) classifies as single speed, mode code 1.
- R5: Any other P commits as unsupported: unsupported flag 1, valid 0, mode code 0. Valid and unsupported are never 1 together, and valid implies a nonzero mode.
- R6: The ratio is the number of master-clock rising edges within one frame. Its code is 0 to 6 for 128, 192, 256, 384, 512, 768 and 1024, and 7 for any other count.
- R7: The ratio error flag is set unless the ratio is legal for the band. Single allows 256, 384, 512, 768 and 1024. Double allows 128, 192, 256, 384 and 512. Quad allows 128, 192 and 256. No ratio is legal when the rate is unsupported.
- R8: Outputs change only at a frame edge whose result equals that of the frame before. At a frame edge whose result differs, valid and unsupported both drop to 0 while the mode and ratio outputs hold.
- R9: If no frame-clock rising edge is seen for floor(REF_HZ/4000)+1 reference cycles, valid is cleared, unsupported is set and the mode returns to 0. The ratio outputs hold.
- R10: Both input clocks pass through two reference-clock flops. A frame-clock high value first sampled at reference edge n, after a low sample at edge n-1, acts on the outputs at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock of REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Master (oversampling) clock, asynchronous to ref_clk |
| lrck | input | 1 | Frame clock, one period per stereo frame |
| rate_mode | output | 2 | 0 none, 1 single, 2 double, 3 quad |
| rate_valid | output | 1 | A supported band has been confirmed |
| rate_unsup | output | 1 | The confirmed rate is unsupported, or the frame clock has timed out |
| ratio_code | output | 3 | Encoded master-to-frame ratio |
| ratio_bad | output | 1 | The ratio is not allowed for the band |

## Verification
The bench keeps the default REF_HZ of 100 MHz. It generates the master clock as a whole number of reference cycles and divides it by a chosen ratio to get the frame clock. Because of this, the frame period is an exact integer P. Every band limit can then be hit exactly, along with the period one past it, such as 925/926, 1190/1191, 588/589 and 1851/1852. Ratios between 128 and 1024 stay within reach while the master clock runs at up to half the reference rate. The 25001-cycle timeout is short enough that both a frame-clock stall and the recovery from it fit in one run.

// File: rtl/srate_mode_det.sv
`timescale 1ns/1ps
module srate_mode_det #(
  parameter int REF_HZ  = 100_000_000,
  parameter int S_LO_HZ = 4000,
  parameter int S_HI_HZ = 54000,
  parameter int D_LO_HZ = 84000,
  parameter int D_HI_HZ = 108000,
  parameter int Q_LO_HZ = 170000,
  parameter int Q_HI_HZ = 216000,
  parameter int MCW     = 11
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mclk,
  input  logic       lrck,
  output logic [1:0] rate_mode,
  output logic       rate_valid,
  output logic       rate_unsup,
  output logic [2:0] ratio_code,
  output logic       ratio_bad
);
  localparam int Q_MIN = (REF_HZ + Q_HI_HZ - 1) / Q_HI_HZ;
  localparam int Q_MAX = REF_HZ / Q_LO_HZ;
  localparam int D_MIN = (REF_HZ + D_HI_HZ - 1) / D_HI_HZ;
  localparam int D_MAX = REF_HZ / D_LO_HZ;
  localparam int S_MIN = (REF_HZ + S_HI_HZ - 1) / S_HI_HZ;
  localparam int S_MAX = REF_HZ / S_LO_HZ;
  localparam int TMO   = S_MAX + 1;
  localparam int PW    = $clog2(TMO + 1);
  localparam logic [7:0] OK_S = 8'b0111_1100;
  localparam logic [7:0] OK_D = 8'b0001_1111;
  localparam logic [7:0] OK_Q = 8'b0000_0111;

  logic [2:0]     lr_q, mc_q;
  logic [PW-1:0]  per;
  logic [MCW-1:0] mcn;
  logic [1:0]     band;
  logic [2:0]     rcode;
  logic [7:0]     okmask;
  logic [5:0]     cls, last;

  wire lr_rise = lr_q[1] & ~lr_q[2];
  wire mc_rise = mc_q[1] & ~mc_q[2];
  wire tmo     = (per == PW'(TMO));
  wire in_q    = (per >= PW'(Q_MIN)) && (per <= PW'(Q_MAX));
  wire in_d    = (per >= PW'(D_MIN)) && (per <= PW'(D_MAX));
  wire in_s    = (per >= PW'(S_MIN)) && (per <= PW'(S_MAX));

  assign band = in_q ? 2'd3 : in_d ? 2'd2 : in_s ? 2'd1 : 2'd0;

  always_comb begin
    case (mcn)
      MCW'(128):  rcode = 3'd0;
      MCW'(192):  rcode = 3'd1;
      MCW'(256):  rcode = 3'd2;
      MCW'(384):  rcode = 3'd3;
      MCW'(512):  rcode = 3'd4;
      MCW'(768):  rcode = 3'd5;
      MCW'(1024): rcode = 3'd6;
      default:    rcode = 3'd7;
    endcase
    case (band)
      2'd1:    okmask = OK_S;
      2'd2:    okmask = OK_D;
      2'd3:    okmask = OK_Q;
      default: okmask = 8'h00;
    endcase
  end

  assign cls = {band, rcode, ~okmask[rcode]};

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= '0;
      mc_q <= '0;
    end else begin
      lr_q <= {lr_q[1:0], lrck};
      mc_q <= {mc_q[1:0], mclk};
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      per        <= '0;
      mcn        <= '0;
      last       <= '0;
      rate_mode  <= '0;
      rate_valid <= 1'b0;
      rate_unsup <= 1'b0;
      ratio_code <= '0;
      ratio_bad  <= 1'b0;
    end else if (lr_rise) begin
      per  <= PW'(1);
      mcn  <= MCW'(mc_rise);
      last <= cls;
      if (cls == last) begin
        rate_mode  <= cls[5:4];
        ratio_code <= cls[3:1];
        ratio_bad  <= cls[0];
        rate_valid <= (cls[5:4] != 2'd0);
        rate_unsup <= (cls[5:4] == 2'd0);
      end else begin
        rate_valid <= 1'b0;
        rate_unsup <= 1'b0;
      end
    end else begin
      if (!tmo) per <= per + PW'(1);
      if (mc_rise && mcn != '1) mcn <= mcn + MCW'(1);
      if (tmo) begin
        rate_valid <= 1'b0;
        rate_unsup <= 1'b1;
        rate_mode  <= 2'd0;
      end
    end
  end

  a_r5_valid_excludes_unsup: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rate_valid |-> (!rate_unsup && rate_mode != 2'd0));

  a_r7_quad_legal_ratio: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rate_valid && rate_mode == 2'd3 && !ratio_bad) |-> (ratio_code <= 3'd2));

  a_r8_hold_between_frames: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!lr_rise && !tmo) |=> ($stable(rate_mode) && $stable(ratio_code) && $stable(ratio_bad)
                            && $stable(rate_valid) && $stable(rate_unsup)));

  a_r9_timeout_flags: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (tmo && !lr_rise) |=> (!rate_valid && rate_unsup && rate_mode == 2'd0));
endmodule

// File: tb/test_srate_mode_det.sv
`timescale 1ns/1ps
module test_srate_mode_det;
  localparam int CLK_PERIOD = 10;
  localparam longint REF = 100_000_000;
  localparam int TMO = 25001;
  localparam int WD_CYCLES = 190_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0;
  logic lrck = 1'b0;
  logic [1:0] rate_mode;
  logic rate_valid, rate_unsup, ratio_bad;
  logic [2:0] ratio_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  srate_mode_det i_srate_mode_det (
    .ref_clk(clk), .rst_n(rst_n), .mclk(mclk), .lrck(lrck),
    .rate_mode(rate_mode), .rate_valid(rate_valid), .rate_unsup(rate_unsup),
    .ratio_code(ratio_code), .ratio_bad(ratio_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus generator: mclk = g_n ref cycles, lrck = g_r mclk periods
  int g_n = 2, g_r = 256, ph = 0, idx = 0;
  bit g_on = 0;
  always @(negedge clk) begin
    ph = ph + 1;
    if (ph >= g_n) begin
      ph = 0;
      idx = idx + 1;
      if (idx >= g_r) idx = 0;
    end
    mclk = (ph < g_n / 2);
    lrck = g_on && (idx < g_r / 2);
  end

  // behavioural reference model
  int lq[$] = '{0, 0, 0};
  int mq[$] = '{0, 0, 0};
  int per_m = 0, mc_m = 0;
  int last_b = 0, last_c = 0, last_e = 0;
  int m_mode = 0, m_valid = 0, m_unsup = 0, m_code = 0, m_bad = 0;

  function automatic int band_of(longint p);
    if (p * 216000 >= REF && p * 170000 <= REF) return 3;
    if (p * 108000 >= REF && p * 84000  <= REF) return 2;
    if (p * 54000  >= REF && p * 4000   <= REF) return 1;
    return 0;
  endfunction

  function automatic int code_of(int r);
    case (r)
      128: return 0; 192: return 1; 256: return 2; 384: return 3;
      512: return 4; 768: return 5; 1024: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int legal(int b, int r);
    if (b == 1) return int'(r inside {256, 384, 512, 768, 1024});
    if (b == 2) return int'(r inside {128, 192, 256, 384, 512});
    if (b == 3) return int'(r inside {128, 192, 256});
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lq = '{0, 0, 0}; mq = '{0, 0, 0};
      per_m = 0; mc_m = 0; last_b = 0; last_c = 0; last_e = 0;
      m_mode = 0; m_valid = 0; m_unsup = 0; m_code = 0; m_bad = 0;
    end else begin
      bit lr_r, mr;
      lr_r = (lq[1] == 1) && (lq[2] == 0);
      mr   = (mq[1] == 1) && (mq[2] == 0);
      if (lr_r) begin
        int b, c, e;
        b = band_of(per_m);
        c = code_of(mc_m);
        e = 1 - legal(b, mc_m);
        if (b == last_b && c == last_c && e == last_e) begin
          m_mode = b; m_code = c; m_bad = e;
          m_valid = (b != 0); m_unsup = (b == 0);
        end else begin
          m_valid = 0; m_unsup = 0;
        end
        last_b = b; last_c = c; last_e = e;
        per_m = 1;
        mc_m = mr;
      end else begin
        if (per_m == TMO) begin
          m_valid = 0; m_unsup = 1; m_mode = 0;
        end else per_m = per_m + 1;
        if (mr && mc_m < 2047) mc_m = mc_m + 1;
      end
      lq.push_front(int'(lrck)); void'(lq.pop_back());
      mq.push_front(int'(mclk)); void'(mq.pop_back());
    end
  end

  // per-cycle comparison (R10 timing, R2-R9 content)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (rate_mode != m_mode[1:0] || rate_valid != m_valid[0] || rate_unsup != m_unsup[0] ||
          ratio_code != m_code[2:0] || ratio_bad != m_bad[0]) begin
        bad++;
        $display("FAIL R10/R8 cycle compare at %0t: got mode=%0d v=%0b u=%0b code=%0d bad=%0b, exp mode=%0d v=%0d u=%0d code=%0d bad=%0d",
                 $time, rate_mode, rate_valid, rate_unsup, ratio_code, ratio_bad,
                 m_mode, m_valid, m_unsup, m_code, m_bad);
      end
    end
  end

  task automatic chk(string tag, int em, int ev, int eu, int ec, int eb);
    total++;
    if (rate_mode != em[1:0] || rate_valid != ev[0] || rate_unsup != eu[0] ||
        ratio_code != ec[2:0] || ratio_bad != eb[0]) begin
      bad++;
      $display("FAIL %s: got mode=%0d v=%0b u=%0b code=%0d bad=%0b, exp mode=%0d v=%0d u=%0d code=%0d bad=%0d",
               tag, rate_mode, rate_valid, rate_unsup, ratio_code, ratio_bad, em, ev, eu, ec, eb);
    end
  endtask

  task automatic play(int n, int r, int frames);
    @(posedge clk);
    g_n = n; g_r = r; g_on = 1;
    repeat (frames * n * r + 20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 0, 0, 0, 0, 0);

    play(2, 256, 5);  chk("R2 quad 256", 3, 1, 0, 2, 0);
    play(3, 192, 5);  chk("R2 quad 192", 3, 1, 0, 1, 0);
    play(4, 128, 5);  chk("R2 quad 128", 3, 1, 0, 0, 0);
    play(2, 288, 5);  chk("R7 quad illegal ratio", 3, 1, 0, 7, 1);
    play(2, 294, 5);  chk("R2 quad upper edge P=588", 3, 1, 0, 7, 1);
    play(19, 31, 5);  chk("R5 P=589 above quad edge", 0, 0, 1, 7, 1);

    play(2, 256, 5);  chk("R2 quad before switch", 3, 1, 0, 2, 0);
    @(posedge clk); g_n = 8; g_r = 128;
    repeat (1536) @(negedge clk);
    chk("R8 valid dropped, outputs held", 3, 0, 0, 2, 0);
    repeat (4096) @(negedge clk);
    chk("R3 double 128", 2, 1, 0, 0, 0);

    play(2, 512, 5);  chk("R3 double 512", 2, 1, 0, 4, 0);
    play(3, 341, 5);  chk("R6 double odd ratio", 2, 1, 0, 7, 1);
    play(2, 463, 5);  chk("R3 double lower edge P=926", 2, 1, 0, 7, 1);
    play(5, 185, 5);  chk("R5 P=925 gap", 0, 0, 1, 7, 1);
    play(2, 595, 5);  chk("R3 double upper edge P=1190", 2, 1, 0, 7, 1);
    play(3, 397, 5);  chk("R5 P=1191 gap", 0, 0, 1, 7, 1);

    play(2, 1024, 5); chk("R4 single 1024", 1, 1, 0, 6, 0);
    play(3, 768, 5);  chk("R4 single 768", 1, 1, 0, 5, 0);
    play(16, 128, 5); chk("R7 single 128 illegal", 1, 1, 0, 0, 1);
    play(2, 926, 5);  chk("R4 single lower edge P=1852", 1, 1, 0, 7, 1);
    play(3, 617, 5);  chk("R5 P=1851 gap", 0, 0, 1, 7, 1);
    play(5, 256, 5);  chk("R5 gap 78 kHz", 0, 0, 1, 2, 1);
    play(2, 200, 5);  chk("R5 above quad band", 0, 0, 1, 7, 1);

    play(2, 256, 5);  chk("R2 quad before stall", 3, 1, 0, 2, 0);
    @(posedge clk); g_on = 0;
    repeat (TMO - 200) @(negedge clk);
    chk("R9 not yet timed out", 3, 1, 0, 2, 0);
    repeat (400) @(negedge clk);
    chk("R9 timeout", 0, 0, 1, 2, 0);
    play(4, 128, 5);  chk("R9 recovery quad 128", 3, 1, 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog: got running, exp finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule